// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block keeps a small set of recently used page translations so that most memory references avoid a page table walk. Each slot holds a virtual page number as its tag and the whole page table entry (frame number plus property bits) as its value. A lookup compares the virtual page of the request against every valid slot at once and answers in the same cycle. On a hit it returns the cached entry and the physical address, built from the entry's frame number and the 12-bit offset of a 4 KB page. On a miss it raises a request toward the external walker, which later returns the translation through the refill port.

Software keeps the buffer consistent with the page tables through two paths. A single-page invalidate, carrying a virtual address, drops only the slot for that page. A write to the page table base register flushes every slot. When the buffer is full, a refill replaces the least recently used slot. Recency is tracked with one age counter per slot.

Top module: `tlb_fa`

## Requirements
- R1: After reset deassertion the buffer holds no translation, so every lookup misses until a refill is accepted.
- R2: Lookup is combinational. In the cycle of a request, `lk_hit_o` shows whether a valid slot's tag equals VA[31:12], and `lk_miss_o` equals the request gated by the inverse of the hit.
- R3: On a hit, `lk_pte_o` is the stored entry and `lk_pa_o` is that entry's bits [31:12] joined with VA[11:0]. On a miss, `lk_pte_o` is zero.
- R4: A refill is installed only when bit 0 (present) of its entry is 1. A refill with bit 0 clear leaves the buffer unchanged.
- R5: A refill whose page number is already cached overwrites that slot in place. It neither evicts another slot nor creates a second copy.
- R6: Capacity is the parameter ENTRIES (16 to 48, default 32). A refill of a new page into a full buffer replaces the slot whose last use (a lookup hit or a refill) is oldest.
- R7: An invalidate request removes only the slot whose tag equals its VA[31:12]. All other slots keep their translations and their relative recency.
- R8: A lookup and an invalidate of the same page in the same cycle report a miss.
- R9: A page table base write clears every slot at the next edge. A lookup in the same cycle as the write misses.
- R10: When several maintenance requests arrive in one cycle, only the highest is applied: base write first, then invalidate, then refill. A lookup hit updates recency only in a cycle with no base write, no invalidate request and no refill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss, request to the walker |
| lk_pte_o | output | PTE_W | Cached page table entry on a hit, zero otherwise |
| lk_pa_o | output | PTE_W | Physical address on a hit |
| fill_req_i | input | 1 | Refill from the walker |
| fill_vpn_i | input | VA_W-12 | Virtual page number of the refill |
| fill_pte_i | input | PTE_W | Page table entry of the refill |
| inv_req_i | input | 1 | Single-page invalidate |
| inv_va_i | input | VA_W | Virtual address to invalidate |
| base_wr_i | input | 1 | Page table base written, flush all |

## Verification
The assertions check on every cycle that a hit never returns an entry with its present bit clear, and that a same-cycle invalidate of the looked-up page forces a miss. They also check that a lookup never hits in the cycle after an invalidate of its page or after a base write. Eviction order, in-place overwrite, the drop of lower-priority maintenance requests and the lack of recency update on busy cycles depend on long histories. Only the bench's reference model can show them: it keeps its own recency queue and compares every output on every cycle, through directed sequences and a long random mix.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PG_OFF_W  = 12;  // 4 KB pages
  localparam int unsigned PRESENT_B = 0;   // present bit in the entry
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N     = 32,
  parameter int unsigned TAG_W = 20
) (
  input  logic [N-1:0]     vld_i,
  input  logic [TAG_W-1:0] tag_i [N],
  input  logic [TAG_W-1:0] key_i,
  output logic [N-1:0]     hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = vld_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_lru.sv
// Valid slots carry distinct ages 0..k-1; age N-1 marks the LRU slot of a full buffer.
module tlb_lru #(
  parameter int unsigned N = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     vld_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic             drop_i,
  input  logic [IDX_W-1:0] drop_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(N - 1);

  logic [IDX_W-1:0] age_q [N];
  logic [IDX_W-1:0] ref_age, drop_age;

  // a newly installed slot ages every valid slot
  assign ref_age  = vld_i[touch_idx_i] ? age_q[touch_idx_i] : AGE_MAX;
  assign drop_age = age_q[drop_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= '0;
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g))                    age_q[g] <= '0;
        else if (vld_i[g] && (age_q[g] < ref_age))       age_q[g] <= age_q[g] + 1'b1;
      end else if (drop_i) begin
        if (vld_i[g] && (age_q[g] > drop_age))           age_q[g] <= age_q[g] - 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !vld_i[i]) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == AGE_MAX) victim_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PTE_W   = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lk_req_i,
  input  logic [VA_W-1:0]          lk_va_i,
  output logic                     lk_hit_o,
  output logic                     lk_miss_o,
  output logic [PTE_W-1:0]         lk_pte_o,
  output logic [PTE_W-1:0]         lk_pa_o,
  input  logic                     fill_req_i,
  input  logic [VA_W-PG_OFF_W-1:0] fill_vpn_i,
  input  logic [PTE_W-1:0]         fill_pte_i,
  input  logic                     inv_req_i,
  input  logic [VA_W-1:0]          inv_va_i,
  input  logic                     base_wr_i
);
  localparam int unsigned VPN_W = VA_W - PG_OFF_W;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PTE_W-1:0]   pte_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, inv_match, fill_match, lk_sel;
  logic [IDX_W-1:0]   lk_idx, inv_idx, fill_idx, victim_idx;
  logic               do_inv, do_fill, lk_touch;

  function automatic logic [IDX_W-1:0] enc(input logic [ENTRIES-1:0] m);
    enc = '0;
    for (int i = 0; i < ENTRIES; i++) if (m[i]) enc = enc | IDX_W'(i);
  endfunction

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_cmp (
    .vld_i(vld_q), .tag_i(tag_q), .key_i(lk_va_i[VA_W-1:PG_OFF_W]), .hit_o(lk_match));
  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_inv_cmp (
    .vld_i(vld_q), .tag_i(tag_q), .key_i(inv_va_i[VA_W-1:PG_OFF_W]), .hit_o(inv_match));
  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fill_cmp (
    .vld_i(vld_q), .tag_i(tag_q), .key_i(fill_vpn_i), .hit_o(fill_match));

  // flush and same-page invalidate mask the lookup
  always_comb begin
    lk_sel = '0;
    if (lk_req_i && !base_wr_i) lk_sel = lk_match & ~(inv_req_i ? inv_match : '0);
  end

  assign lk_hit_o  = |lk_sel;
  assign lk_miss_o = lk_req_i && !lk_hit_o;
  assign lk_idx    = enc(lk_sel);
  assign inv_idx   = enc(inv_match);

  always_comb begin
    lk_pte_o = '0;
    for (int i = 0; i < ENTRIES; i++) if (lk_sel[i]) lk_pte_o = lk_pte_o | pte_q[i];
  end
  assign lk_pa_o = {lk_pte_o[PTE_W-1:PG_OFF_W], lk_va_i[PG_OFF_W-1:0]};

  // priority: base write > invalidate > refill
  assign do_inv   = !base_wr_i && inv_req_i && |inv_match;
  assign do_fill  = !base_wr_i && !inv_req_i && fill_req_i && fill_pte_i[PRESENT_B];
  assign fill_idx = |fill_match ? enc(fill_match) : victim_idx;
  assign lk_touch = lk_hit_o && !inv_req_i && !fill_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        vld_q <= '0;
    else if (base_wr_i) vld_q <= '0;
    else if (do_inv)    vld_q[inv_idx] <= 1'b0;
    else if (do_fill)   vld_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (do_fill) begin
      tag_q[fill_idx] <= fill_vpn_i;
      pte_q[fill_idx] <= fill_pte_i;
    end
  end

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (vld_q),
    .touch_i    (do_fill || lk_touch),
    .touch_idx_i(do_fill ? fill_idx : lk_idx),
    .drop_i     (do_inv),
    .drop_idx_i (inv_idx),
    .victim_o   (victim_idx)
  );
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PTE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_req_i,
  input logic [VA_W-1:0]  lk_va_i,
  input logic             lk_hit_o,
  input logic [PTE_W-1:0] lk_pte_o,
  input logic             inv_req_i,
  input logic [VA_W-1:0]  inv_va_i,
  input logic             base_wr_i
);
  localparam int unsigned OFF = 12;

  assert_hit_present_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_pte_o[0]);

  assert_flush_next_miss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> !lk_hit_o);

  assert_inv_same_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && inv_req_i && (lk_va_i[VA_W-1:OFF] == inv_va_i[VA_W-1:OFF])) |-> !lk_hit_o);

  assert_inv_removes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && $past(inv_req_i) && (lk_va_i[VA_W-1:OFF] == $past(inv_va_i[VA_W-1:OFF])))
      |-> !lk_hit_o);
endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PTE_W(PTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_va_i(lk_va_i),
  .lk_hit_o(lk_hit_o), .lk_pte_o(lk_pte_o), .inv_req_i(inv_req_i),
  .inv_va_i(inv_va_i), .base_wr_i(base_wr_i));

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;
  localparam int N = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_req = 0, fill_req = 0, inv_req = 0, base_wr = 0;
  logic [31:0] lk_va = '0, inv_va = '0, fill_pte = '0;
  logic [19:0] fill_vpn = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_pte, lk_pa;

  always #4 clk = ~clk;

  tlb_fa #(.ENTRIES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lk_req_i(lk_req), .lk_va_i(lk_va),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_pte_o(lk_pte), .lk_pa_o(lk_pa),
    .fill_req_i(fill_req), .fill_vpn_i(fill_vpn), .fill_pte_i(fill_pte),
    .inv_req_i(inv_req), .inv_va_i(inv_va), .base_wr_i(base_wr));

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";
  logic [31:0] m_pte [int unsigned];
  int unsigned order[$];   // most recent first

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic to_front(int unsigned v);
    foreach (order[i]) if (order[i] == v) begin order.delete(i); break; end
    order.push_front(v);
  endtask

  // inputs set by caller at negedge; compare, then advance model at posedge
  task automatic step();
    int unsigned v;
    bit e_hit;
    logic [31:0] e_pte;
    #1;
    v = lk_va[31:12];
    e_hit = lk_req && !base_wr && !(inv_req && inv_va[31:12] == v) && m_pte.exists(v);
    e_pte = e_hit ? m_pte[v] : 32'h0;
    chk(lk_hit == e_hit, "hit", 32'(lk_hit), 32'(e_hit));
    chk(lk_miss == (lk_req && !e_hit), "miss", 32'(lk_miss), 32'(lk_req && !e_hit));
    chk(lk_pte == e_pte, "pte", lk_pte, e_pte);
    if (e_hit) chk(lk_pa == {e_pte[31:12], lk_va[11:0]}, "pa", lk_pa, {e_pte[31:12], lk_va[11:0]});
    @(posedge clk);
    if (base_wr) begin
      m_pte.delete();
      order.delete();
    end else if (inv_req) begin
      int unsigned iv;
      iv = inv_va[31:12];
      if (m_pte.exists(iv)) begin
        m_pte.delete(iv);
        foreach (order[i]) if (order[i] == iv) begin order.delete(i); break; end
      end
    end else if (fill_req && fill_pte[0]) begin
      int unsigned fv;
      fv = fill_vpn;
      if (!m_pte.exists(fv) && order.size() == N) m_pte.delete(order.pop_back());
      m_pte[fv] = fill_pte;
      to_front(fv);
    end else if (e_hit && !fill_req) begin
      to_front(v);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    lk_req = 0; fill_req = 0; inv_req = 0; base_wr = 0;
  endtask

  task automatic look(int unsigned v, logic [11:0] off);
    idle(); lk_req = 1; lk_va = {v[19:0], off}; step();
  endtask

  task automatic fill(int unsigned v, logic [31:0] p);
    idle(); fill_req = 1; fill_vpn = v[19:0]; fill_pte = p; step();
  endtask

  task automatic inval(int unsigned v);
    idle(); inv_req = 1; inv_va = {v[19:0], 12'h123}; step();
  endtask

  task automatic flush();
    idle(); base_wr = 1; step();
  endtask

  function automatic logic [31:0] mk(int unsigned v);
    return {v[7:0] ^ 8'h5A, v[11:0] + 12'h301, 12'h0E7};
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R1";
    for (int i = 0; i < 5; i++) look(i * 7, 12'h010);

    tag = "R3";
    for (int i = 1; i <= 5; i++) fill(i, mk(i));
    for (int i = 1; i <= 5; i++) look(i, 12'(i * 333));
    look(9, 12'hFFF);

    tag = "R4";
    fill(100, 32'hABCDE0E6);
    look(100, 12'h000);

    tag = "R5";
    fill(3, 32'h12345F01);
    look(3, 12'h444);

    tag = "R6";
    flush();
    for (int i = 0; i < N; i++) fill(200 + i, mk(200 + i));
    look(200, 12'h001);
    fill(300, mk(300));
    look(201, 12'h002);
    look(200, 12'h003);
    fill(200 + 5, 32'h0F0F0001);
    fill(301, mk(301));
    for (int i = 0; i < N; i++) look(200 + i, 12'h004);
    look(300, 12'h005);
    look(301, 12'h006);

    tag = "R7";
    inval(210);
    look(210, 12'h0);
    look(211, 12'h0);
    look(212, 12'h0);

    tag = "R8";
    idle(); lk_req = 1; lk_va = {20'd213, 12'h7}; inv_req = 1; inv_va = {20'd213, 12'h9}; step();
    look(213, 12'h7);
    look(214, 12'h7);

    tag = "R10";
    idle(); inv_req = 1; inv_va = {20'd215, 12'h0}; fill_req = 1; fill_vpn = 20'd400; fill_pte = mk(400); step();
    look(400, 12'h0);
    idle(); lk_req = 1; lk_va = {20'd216, 12'h0}; fill_req = 1; fill_vpn = 20'd401; fill_pte = mk(401); step();
    for (int i = 0; i < 4; i++) fill(500 + i, mk(500 + i));
    for (int i = 0; i < N; i++) look(200 + i, 12'h0);

    tag = "R9";
    idle(); base_wr = 1; lk_req = 1; lk_va = {20'd217, 12'h0}; fill_req = 1; fill_vpn = 20'd600; fill_pte = mk(600); step();
    look(217, 12'h0);
    look(600, 12'h0);

    tag = "R2";
    for (int c = 0; c < 4000; c++) begin
      int unsigned r;
      idle();
      r = $urandom_range(99);
      lk_req = ($urandom_range(3) != 0);
      lk_va = {20'($urandom_range(47)), 12'($urandom)};
      if (r < 30) begin
        fill_req = 1; fill_vpn = 20'($urandom_range(47));
        fill_pte = {20'($urandom), 11'($urandom), ($urandom_range(7) != 0)};
      end else if (r < 36) begin
        inv_req = 1; inv_va = {20'($urandom_range(47)), 12'($urandom)};
      end else if (r == 36) begin
        base_wr = 1;
      end
      step();
    end

    idle();
    finished = 1;
    summary();
    $finish;
  end
endmodule